// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the address used by one port of a synchronous RAM in each clock cycle. In any cycle the address comes from one of four sources. It can be the external address bus, taken through with no delay. It can be the previous cycle's address plus one. It can be the previous cycle's address unchanged. It can be the address captured by the most recent load. Three active-low strobes pick the source.

A separate anchor register keeps the last externally loaded address. A burst can therefore restart from its origin in the very cycle the repeat strobe is low, with no idle cycle. A read or write can use the restarted address in that same cycle. The access address is combinational from the strobes, the external bus and two registers. A RAM placed beside the block can use it in the same cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: With `again_n` high and `load_n` low, `acc_addr` equals `ext_addr` in the same cycle. That value is captured at the next rising edge.
- R2: With `again_n` high, `load_n` high and `step_n` low, `acc_addr` equals the previous cycle's `acc_addr` plus one.
- R3: With `again_n`, `load_n` and `step_n` all high, `acc_addr` equals the previous cycle's `acc_addr`.
- R4: With `again_n` low, `acc_addr` equals the `ext_addr` of the most recent load cycle. This holds whatever the values of `load_n` and `step_n`.
- R5: The strobes have a fixed priority: repeat wins over load, load wins over advance, and advance wins over hold. When `again_n` and `load_n` are both low, `ext_addr` is neither used nor captured.
- R6: The anchor changes only in load cycles. Advance, hold and repeat cycles, including a repeat that coincides with a low `load_n`, leave it unchanged.
- R7: An advance from the all-ones address gives zero.
- R8: A synchronous reset (`rst_n` low at a rising edge) clears both the running address and the anchor to zero. The next hold cycle and the next repeat cycle therefore both show zero.
- R9: Loads in consecutive cycles take arbitrary, non-sequential addresses, one for each cycle.
- R10: An advance after a repeat continues from the anchor, so it gives anchor plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Take the external address and store it as the anchor, active low |
| step_n | input | 1 | Advance the running address by one, active low |
| again_n | input | 1 | Restart from the anchor, active low |
| ext_addr | input | ADDR_W (18) | External address |
| acc_addr | output | ADDR_W (18) | Address accessed in the current cycle |

## Verification
A repeat can fall in the same cycle as a load strobe. It can also fall in the same cycle as an advance strobe. The bench provokes these overlaps by driving every combination of the three strobes against a sweep of external addresses on a 4-bit configuration. The expected address follows the stated priority. A directed case sends a repeat together with a load of a new address and then sends a second repeat. That second repeat must still return the old anchor, which shows that the coinciding load was discarded rather than captured.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
// Assumes: one source of the address is selected in each cycle.
package burst_addr_pkg;

    // Address source chosen for the current cycle
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_STEP  = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_AGAIN = 2'd3
    } addr_src_e;

endpackage

// File: rtl/burst_src_decode.sv
// Turns the three active-low strobes into a single source selection.
// Assumes: priority is repeat, then load, then advance, then hold.
module burst_src_decode
    import burst_addr_pkg::*;
(
    input  logic      load_n,
    input  logic      step_n,
    input  logic      again_n,
    output addr_src_e src
);

    // Fixed-priority choice of the address source
    always_comb begin
        if (!again_n)     src = SRC_AGAIN;
        else if (!load_n) src = SRC_LOAD;
        else if (!step_n) src = SRC_STEP;
        else              src = SRC_HOLD;
    end

endmodule

// File: rtl/burst_anchor_reg.sv
// Stores the most recent externally loaded address.
// Assumes: a synchronous active-low reset; updated only when capture is set.
module burst_anchor_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Capture the loaded address, or clear it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end

endmodule

// File: rtl/burst_addr_path.sv
// Forms the access address and keeps the running address register.
// Assumes: the running register always holds the previous cycle's access
// address, so an advance adds one to it and a hold reuses it. The width
// sets the wrap point.
module burst_addr_path
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] anchor,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] run_q;

    // Select this cycle's address from the chosen source
    always_comb begin
        unique case (src)
            SRC_AGAIN: acc_addr = anchor;
            SRC_LOAD:  acc_addr = ext_addr;
            SRC_STEP:  acc_addr = run_q + ONE;
            default:   acc_addr = run_q;
        endcase
    end

    // Remember the address used so the next cycle can step or hold it
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= acc_addr;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Top of the per-port burst address generator.
// Assumes: the strobes and ext_addr are synchronous to clk. acc_addr is
// combinational and meant for the access in the same cycle.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              again_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    addr_src_e         src;
    logic [ADDR_W-1:0] anchor;
    logic              take_anchor;

    burst_src_decode u_dec (
        .load_n  (load_n),
        .step_n  (step_n),
        .again_n (again_n),
        .src     (src)
    );

    // Only a winning load updates the anchor
    assign take_anchor = (src == SRC_LOAD);

    burst_anchor_reg #(.ADDR_W(ADDR_W)) u_anchor (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (take_anchor),
        .d       (ext_addr),
        .q       (anchor)
    );

    burst_addr_path #(.ADDR_W(ADDR_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .ext_addr (ext_addr),
        .anchor   (anchor),
        .acc_addr (acc_addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Temporal checks on the ports of burst_addr_gen, attached by bind.
// Assumes: the previous-cycle address is valid only one full cycle after reset.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              step_n,
    input logic              again_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] last_load;
    logic              prev_ok;

    // Observe the previous address and the last winning load at the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ok   <= 1'b0;
            last_load <= '0;
        end else begin
            prev_ok <= 1'b1;
            if (again_n && !load_n) last_load <= ext_addr;
        end
        prev_addr <= acc_addr;
    end

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && again_n && load_n && !step_n) |-> acc_addr == ADDR_W'(prev_addr + ADDR_W'(1)));

    // R3
    hold_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && again_n && load_n && step_n) |-> acc_addr == prev_addr);

    // R4
    again_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!again_n) |-> acc_addr == last_load);

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && again_n && load_n && !step_n && prev_addr == {ADDR_W{1'b1}}) |-> acc_addr == '0);

    // R1
    load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (again_n && !load_n) |=> (!again_n) |-> acc_addr == $past(ext_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .step_n   (step_n),
    .again_n  (again_n),
    .ext_addr (ext_addr),
    .acc_addr (acc_addr)
);

// File: tb/sim_burst_addr_gen.sv
// Sweeps every strobe combination on a 4-bit build and compares the access
// address with values derived arithmetically from the requirements.
module sim_burst_addr_gen;

    localparam int AW = 4;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          step_n = 1'b1;
    logic          again_n = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;

    int errors = 0;
    int checks = 0;
    int m_prev = 0;
    int m_anchor = 0;
    bit finished = 1'b0;

    burst_addr_gen #(.ADDR_W(AW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .step_n   (step_n),
        .again_n  (again_n),
        .ext_addr (ext_addr),
        .acc_addr (acc_addr)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // One cycle: drive at the falling edge, check mid-cycle, update the model at the rising edge
    task automatic step(input bit ld, input bit st, input bit ag, input int ext,
                        input string req, input bit do_check);
        int exp;
        @(negedge clk);
        load_n = ld; step_n = st; again_n = ag; ext_addr = AW'(ext);
        #2;
        if (!ag)      exp = m_anchor;
        else if (!ld) exp = ext & MASK;
        else if (!st) exp = (m_prev + 1) & MASK;
        else          exp = m_prev;
        if (do_check) begin
            checks++;
            if (int'(acc_addr) != exp) begin
                errors++;
                $display("FAIL %s: acc_addr=%0d expected=%0d", req, acc_addr, exp);
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            m_prev = 0; m_anchor = 0;
        end else begin
            m_prev = exp;
            if (ag && !ld) m_anchor = ext & MASK;
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        step(1, 1, 1, 0, "R8", 0);
        step(1, 1, 1, 0, "R8", 0);
        rst_n = 1'b1;
        step(1, 1, 1, 0, "R8", 1);   // R8 hold after reset reads zero
        step(1, 1, 0, 0, "R8", 1);   // R8 repeat after reset reads zero
        step(0, 1, 1, 5, "R1", 1);
        step(1, 0, 1, 0, "R2", 1);
        step(1, 0, 1, 0, "R2", 1);
        step(1, 0, 1, 0, "R2", 1);
        step(1, 1, 1, 0, "R3", 1);
        step(1, 1, 0, 0, "R4", 1);   // back to 5
        step(1, 0, 1, 0, "R10", 1);  // 6
        step(0, 0, 0, 9, "R5", 1);   // repeat wins over load
        step(1, 1, 0, 0, "R6", 1);   // anchor still 5
        step(0, 0, 1, 12, "R5", 1);  // load wins over advance
        step(0, 1, 1, 3, "R9", 1);
        step(0, 1, 1, 11, "R9", 1);
        step(0, 1, 1, 7, "R9", 1);
        step(0, 1, 1, 14, "R1", 1);
        step(1, 0, 1, 0, "R2", 1);   // 15
        step(1, 0, 1, 0, "R7", 1);   // wraps to 0
        step(1, 0, 0, 0, "R4", 1);   // repeat wins over advance
        // Sweep all strobe combinations against every external value
        for (int pass = 0; pass < 3; pass++) begin
            for (int e = 0; e <= MASK; e++) begin
                for (int c = 0; c < 8; c++) begin
                    step(c[0], c[1], c[2], (e * 7 + pass * 5 + c) & MASK,
                         !c[2] ? "R4" : (!c[0] ? "R1" : (!c[1] ? "R2" : "R3")), 1);
                end
            end
        end
        // Mid-run reset clears both registers
        step(0, 1, 1, 10, "R1", 1);
        rst_n = 1'b0;
        step(1, 1, 1, 0, "R8", 0);
        rst_n = 1'b1;
        step(1, 1, 1, 0, "R8", 1);
        step(1, 1, 0, 0, "R8", 1);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: acc_addr=%0d expected=completion", acc_addr);
        finish_run();
    end

endmodule